// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

A passive observer for the command and address lines of a four-bank SDRAM. On every rising clock edge it decides whether a command was really presented: the edge counts only if clock enable was high on the previous edge and chip select is low on this one. It decodes the row strobe, column strobe and write enable into a command. It tracks which banks hold an open row. It keeps saturating counters of the edges elapsed since the last activate and the last precharge of each bank, since the last activate to any bank, and since the last mode-register load.

Each command is checked against the bank state and the minimum clock gaps. When a rule breaks, the monitor latches a 3-bit error code and the bank at fault. That first error stays on the outputs until reset, so a long regression only has to look at the flag at the end of the run. The monitor drives nothing onto the memory bus.

A gap between two commands is the number of rising edges from the edge of the first command to the edge of the second. Commands on consecutive edges have a gap of 1.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: On an edge that counts, with chip select low, the low-active lines {row strobe, column strobe, write enable} decode as follows: 011 ACTIVATE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH and 000 MODE LOAD. The values 111 and 110 cause no action.
- R2: An edge with chip select high carries no command. The elapsed-edge counters still advance on that edge.
- R3: An edge that follows an edge with clock enable low carries no command. The counters still advance on it.
- R4: ACTIVATE opens the addressed bank. PRECHARGE with the all-bank line high closes all banks; with that line low it closes only the addressed bank. READ or WRITE to a closed bank, or ACTIVATE to an open bank, gives code 1.
- R5: REFRESH while any bank is open gives code 2. The lowest-numbered open bank is reported.
- R6: READ or WRITE to an open bank with a gap of less than 3 since that bank's ACTIVATE gives code 3.
- R7: PRECHARGE that closes an open bank with a gap of less than 6 since that bank's ACTIVATE gives code 4. For an all-bank precharge, the lowest-numbered such bank is reported.
- R8: ACTIVATE with a gap of less than 3 since a PRECHARGE that addressed the same bank gives code 5. This holds even if that bank was already closed.
- R9: ACTIVATE with a gap of less than 2 since an ACTIVATE to a different bank gives code 6.
- R10: ACTIVATE with a gap of less than 2 since MODE LOAD gives code 7.
- R11: When several rules break on one edge, the lowest code is reported. The reported bank is the addressed bank unless R5 or R7 say otherwise.
- R12: After reset, err_valid, err_code and err_bank are 0. The first error is held unchanged until the next reset, and later errors do not replace it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low makes the next edge carry no command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| ap_line | input | 1 | Address line that selects all-bank precharge |
| err_valid | output | 1 | Sticky error flag |
| err_code | output | 3 | Code of the first error (0 = none) |
| err_bank | output | 2 | Bank at fault in the first error |

## Verification
The hardest situation to reach is an all-bank precharge that finds two open banks of different ages. Whether there is an error, and which bank is reported, then depend on both counters at once. The bench opens bank 1 and then bank 3 two edges later. It sweeps the precharge edge so that both banks violate, then only bank 3, then neither.

The edges that carry no command are reached by placing a command pattern right after a low clock enable, or under a high chip select. The bench then issues a legal command whose legality depends on the counters having advanced through those edges.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  // lower value wins when several rules break on one edge
  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_STATE    = 3'd1,
    ERR_REF_OPEN = 3'd2,
    ERR_RCD      = 3'd3,
    ERR_RAS      = 3'd4,
    ERR_RP       = 3'd5,
    ERR_RRD      = 3'd6,
    ERR_MRD      = 3'd7
  } err_e;

  // strobes are low-active: {ras_n, cas_n, we_n}
  function automatic cmd_e decode_cmd(input logic ras_n, input logic cas_n,
                                      input logic we_n);
    case ({ras_n, cas_n, we_n})
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      3'b000:  return CMD_MRS;
      3'b110:  return CMD_BST;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_mon_gap.sv
// Saturating count of edges since the last restart; starts saturated.
module sdram_mon_gap #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned SAT   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] gap
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)            gap <= SAT_V;
    else if (restart)      gap <= ONE_V;
    else if (gap != SAT_V) gap <= gap + ONE_V;
  end
endmodule

// File: rtl/sdram_mon_decode.sv
module sdram_mon_decode
  import sdram_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic edge_ok,
  output cmd_e cmd
);
  logic cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign edge_ok = cke_q;
  assign cmd     = (edge_ok && !cs_n) ? decode_cmd(ras_n, cas_n, we_n) : CMD_NOP;
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_MRD     = 2,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            ap_line,
  output logic            err_valid,
  output logic [2:0]      err_code,
  output logic [BA_W-1:0] err_bank
);
  localparam int unsigned T_MAX = max2(max2(max2(T_RCD, T_RAS), max2(T_RP, T_RRD)), T_MRD);
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  function automatic logic too_soon(input logic [CNT_W-1:0] gap, input int unsigned lim);
    return gap < CNT_W'(lim);
  endfunction

  function automatic logic [BA_W-1:0] lowest(input logic [NUM_BANKS-1:0] vec);
    logic [BA_W-1:0] idx;
    idx = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--)
      if (vec[b]) idx = BA_W'(b);
    return idx;
  endfunction

  // ---- decode ----
  logic edge_ok;
  cmd_e cmd;

  sdram_mon_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .edge_ok(edge_ok), .cmd(cmd)
  );

  logic is_act, is_rdwr, is_pre, is_ref, is_mrs;
  assign is_act  = (cmd == CMD_ACT);
  assign is_rdwr = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_pre  = (cmd == CMD_PRE);
  assign is_ref  = (cmd == CMD_REF);
  assign is_mrs  = (cmd == CMD_MRS);

  logic [NUM_BANKS-1:0] tgt_hot, pre_mask;
  assign tgt_hot  = NUM_BANKS'(1) << ba;
  assign pre_mask = ap_line ? '1 : tgt_hot;

  // ---- per-bank state ----
  logic [NUM_BANKS-1:0] bank_open;
  logic [CNT_W-1:0]     act_gap [NUM_BANKS];
  logic [CNT_W-1:0]     pre_gap [NUM_BANKS];
  logic [NUM_BANKS-1:0] ras_viol;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_mon_gap #(.CNT_W(CNT_W), .SAT(T_MAX)) u_act_gap (
      .clk(clk), .rst_n(rst_n), .restart(is_act && tgt_hot[b]), .gap(act_gap[b])
    );
    sdram_mon_gap #(.CNT_W(CNT_W), .SAT(T_MAX)) u_pre_gap (
      .clk(clk), .rst_n(rst_n), .restart(is_pre && pre_mask[b]), .gap(pre_gap[b])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                       bank_open[b] <= 1'b0;
      else if (is_act && tgt_hot[b])    bank_open[b] <= 1'b1;
      else if (is_pre && pre_mask[b])   bank_open[b] <= 1'b0;
    end

    assign ras_viol[b] = is_pre && pre_mask[b] && bank_open[b] && too_soon(act_gap[b], T_RAS);
  end

  // ---- cross-bank state ----
  logic [CNT_W-1:0] any_act_gap, mrs_gap;
  logic [BA_W-1:0]  last_act_bank;

  sdram_mon_gap #(.CNT_W(CNT_W), .SAT(T_MAX)) u_any_act_gap (
    .clk(clk), .rst_n(rst_n), .restart(is_act), .gap(any_act_gap)
  );
  sdram_mon_gap #(.CNT_W(CNT_W), .SAT(T_MAX)) u_mrs_gap (
    .clk(clk), .rst_n(rst_n), .restart(is_mrs), .gap(mrs_gap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      last_act_bank <= '0;
    else if (is_act) last_act_bank <= ba;
  end

  // ---- rule checks ----
  logic tgt_open;
  logic e_state, e_ref, e_rcd, e_ras, e_rp, e_rrd, e_mrd;
  assign tgt_open = bank_open[ba];
  assign e_state  = (is_rdwr && !tgt_open) || (is_act && tgt_open);
  assign e_ref    = is_ref && (|bank_open);
  assign e_rcd    = is_rdwr && tgt_open && too_soon(act_gap[ba], T_RCD);
  assign e_ras    = |ras_viol;
  assign e_rp     = is_act && too_soon(pre_gap[ba], T_RP);
  assign e_rrd    = is_act && (ba != last_act_bank) && too_soon(any_act_gap, T_RRD);
  assign e_mrd    = is_act && too_soon(mrs_gap, T_MRD);

  err_e            new_code;
  logic [BA_W-1:0] new_bank;

  always_comb begin
    new_code = ERR_NONE;
    new_bank = ba;
    if      (e_state) new_code = ERR_STATE;
    else if (e_ref)   begin new_code = ERR_REF_OPEN; new_bank = lowest(bank_open); end
    else if (e_rcd)   new_code = ERR_RCD;
    else if (e_ras)   begin new_code = ERR_RAS; new_bank = lowest(ras_viol); end
    else if (e_rp)    new_code = ERR_RP;
    else if (e_rrd)   new_code = ERR_RRD;
    else if (e_mrd)   new_code = ERR_MRD;
  end

  // ---- first-error capture ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_code  <= 3'd0;
      err_bank  <= '0;
    end else if (!err_valid && new_code != ERR_NONE) begin
      err_valid <= 1'b1;
      err_code  <= new_code;
      err_bank  <= new_bank;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 edge_ok,
  input logic                 is_act,
  input logic                 is_pre,
  input logic                 is_ref,
  input logic                 ap_line,
  input logic [BA_W-1:0]      ba,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 err_valid,
  input logic [2:0]           err_code,
  input logic [BA_W-1:0]      err_bank
);
  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_valid && cs_n) |=> !err_valid);

  assert_cke_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_valid && !edge_ok) |=> !err_valid);

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> bank_open[$past(ba)]);

  assert_prea_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && ap_line) |=> (bank_open == '0));

  assert_ref_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_valid && is_ref && (|bank_open)) |=> (err_valid && err_code == 3'd2));

  assert_code_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code != 3'd0));

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> (err_valid && $stable(err_code) && $stable(err_bank)));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .edge_ok(edge_ok),
  .is_act(is_act), .is_pre(is_pre), .is_ref(is_ref), .ap_line(ap_line),
  .ba(ba), .bank_open(bank_open),
  .err_valid(err_valid), .err_code(err_code), .err_bank(err_bank)
);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR  = 3'b100, C_PRE = 3'b010, C_REF = 3'b001,
                         C_MRS = 3'b000;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, ap_line;
  logic [1:0] ba;
  logic err_valid;
  logic [2:0] err_code;
  logic [1:0] err_bank;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_cmd_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap_line(ap_line),
    .err_valid(err_valid), .err_code(err_code), .err_bank(err_bank)
  );

  task automatic drive(input logic sel_n, input logic [2:0] rcw, input logic [1:0] b,
                       input logic ap, input logic ke);
    @(negedge clk);
    cs_n = sel_n; {ras_n, cas_n, we_n} = rcw; ba = b; ap_line = ap; cke = ke;
  endtask

  task automatic op(input logic [2:0] rcw, input logic [1:0] b, input logic ap = 1'b0);
    drive(1'b0, rcw, b, ap, 1'b1);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) op(C_NOP, 2'd0);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
    ba = 2'd0; ap_line = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check(input string req, input logic v, input logic [2:0] c,
                       input logic [1:0] b);
    n_checks++;
    if (err_valid !== v || (v && (err_code !== c || err_bank !== b))) begin
      n_errors++;
      $display("FAIL %s: valid=%0b code=%0d bank=%0d expected valid=%0b code=%0d bank=%0d",
               req, err_valid, err_code, err_bank, v, c, b);
    end
  endtask

  // one NOP edge so the last command's edge has passed, then check
  task automatic settle_check(input string req, input logic v, input logic [2:0] c,
                              input logic [1:0] b);
    op(C_NOP, 2'd0);
    check(req, v, c, b);
  endtask

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
    ba = 2'd0; ap_line = 1'b0;

    // R12 reset state
    do_reset;
    @(negedge clk);
    n_checks++;
    if (err_valid !== 1'b0 || err_code !== 3'd0 || err_bank !== 2'd0) begin
      n_errors++;
      $display("FAIL R12 reset: valid=%0b code=%0d bank=%0d expected 0 0 0",
               err_valid, err_code, err_bank);
    end

    // R6 READ/WRITE after ACTIVATE, every bank, gaps 1..7
    for (int b = 0; b < 4; b++)
      for (int g = 1; g <= 7; g++) begin
        do_reset;
        op(C_ACT, 2'(b));
        nops(g - 1);
        op((g % 2) ? C_RD : C_WR, 2'(b));
        settle_check("R6 rcd", g < 3, 3'd3, 2'(b));
      end

    // R7 single-bank PRECHARGE after ACTIVATE, gaps 1..8
    for (int b = 0; b < 4; b++)
      for (int g = 1; g <= 8; g++) begin
        do_reset;
        op(C_ACT, 2'(b));
        nops(g - 1);
        op(C_PRE, 2'(b), 1'b0);
        settle_check("R7 ras", g < 6, 3'd4, 2'(b));
      end

    // R7 all-bank PRECHARGE with banks 1 and 3 of different ages
    for (int g = 3; g <= 9; g++) begin
      do_reset;
      op(C_ACT, 2'd1);
      op(C_NOP, 2'd0);
      op(C_ACT, 2'd3);
      nops(g - 3);
      op(C_PRE, 2'd0, 1'b1);
      settle_check("R7 ras all-bank", g < 8, 3'd4, (g < 6) ? 2'd1 : 2'd3);
    end

    // R8 ACTIVATE after PRECHARGE, gaps 1..5
    for (int b = 0; b < 4; b++)
      for (int g = 1; g <= 5; g++) begin
        do_reset;
        op(C_ACT, 2'(b));
        nops(5);
        op(C_PRE, 2'(b));
        nops(g - 1);
        op(C_ACT, 2'(b));
        settle_check("R8 rp", g < 3, 3'd5, 2'(b));
      end

    // R9 ACTIVATE to different banks, all ordered pairs, gaps 1..3
    for (int b1 = 0; b1 < 4; b1++)
      for (int b2 = 0; b2 < 4; b2++)
        if (b1 != b2)
          for (int g = 1; g <= 3; g++) begin
            do_reset;
            op(C_ACT, 2'(b1));
            nops(g - 1);
            op(C_ACT, 2'(b2));
            settle_check("R9 rrd", g < 2, 3'd6, 2'(b2));
          end

    // R10 ACTIVATE after MODE LOAD, gaps 1..4
    for (int g = 1; g <= 4; g++) begin
      do_reset;
      op(C_MRS, 2'd0);
      nops(g - 1);
      op(C_ACT, 2'd2);
      settle_check("R10 mrd", g < 2, 3'd7, 2'd2);
    end

    // R5 REFRESH with open banks reports lowest; closed banks give nothing
    do_reset;
    op(C_ACT, 2'd3); op(C_NOP, 2'd0); op(C_ACT, 2'd1);
    nops(6);
    op(C_REF, 2'd0);
    settle_check("R5 refresh open", 1'b1, 3'd2, 2'd1);
    do_reset;
    op(C_REF, 2'd0);
    settle_check("R5 refresh closed", 1'b0, 3'd0, 2'd0);
    do_reset;
    op(C_ACT, 2'd0); nops(5); op(C_PRE, 2'd0, 1'b1); nops(2);
    op(C_REF, 2'd2);
    settle_check("R5 refresh after all-bank close", 1'b0, 3'd0, 2'd0);

    // R4 / R1 state errors
    do_reset;
    op(C_RD, 2'd3);
    settle_check("R4 R1 read closed bank", 1'b1, 3'd1, 2'd3);
    do_reset;
    op(C_WR, 2'd2);
    settle_check("R4 R1 write closed bank", 1'b1, 3'd1, 2'd2);
    do_reset;
    op(C_ACT, 2'd0); nops(6); op(C_ACT, 2'd0);
    settle_check("R4 activate open bank", 1'b1, 3'd1, 2'd0);
    // single-bank precharge leaves the other bank open
    do_reset;
    op(C_ACT, 2'd0); op(C_NOP, 2'd0); op(C_ACT, 2'd2); nops(6);
    op(C_PRE, 2'd0, 1'b0); nops(3);
    op(C_RD, 2'd2);
    settle_check("R4 other bank stays open", 1'b0, 3'd0, 2'd0);
    op(C_RD, 2'd0);
    settle_check("R4 precharged bank closed", 1'b1, 3'd1, 2'd0);

    // R2 deselected edges: pattern ignored, counters advance
    do_reset;
    drive(1'b1, C_RD, 2'd1, 1'b0, 1'b1);
    settle_check("R2 deselected read", 1'b0, 3'd0, 2'd0);
    op(C_ACT, 2'd2);
    drive(1'b1, C_RD, 2'd2, 1'b0, 1'b1);
    drive(1'b1, C_RD, 2'd2, 1'b0, 1'b1);
    op(C_RD, 2'd2);
    settle_check("R2 counters advance when deselected", 1'b0, 3'd0, 2'd0);
    op(C_RD, 2'd1);
    settle_check("R2 R1 selected read decoded", 1'b1, 3'd1, 2'd1);

    // R3 clock-enable gating
    do_reset;
    drive(1'b0, C_NOP, 2'd0, 1'b0, 1'b0);
    op(C_RD, 2'd0);
    settle_check("R3 edge after cke low ignored", 1'b0, 3'd0, 2'd0);
    op(C_ACT, 2'd1);
    drive(1'b0, C_NOP, 2'd0, 1'b0, 1'b0);
    op(C_RD, 2'd1);
    op(C_RD, 2'd1);
    settle_check("R3 counters advance on gated edge", 1'b0, 3'd0, 2'd0);
    op(C_WR, 2'd0);
    settle_check("R3 R1 monitor live after gating", 1'b1, 3'd1, 2'd0);

    // R11 priority: same edge breaks tRP (5) and tRRD (6)
    do_reset;
    op(C_PRE, 2'd0);
    op(C_ACT, 2'd1);
    op(C_ACT, 2'd0);
    settle_check("R11 priority rp over rrd", 1'b1, 3'd5, 2'd0);

    // R12 first error held, then cleared by reset
    do_reset;
    op(C_RD, 2'd1);
    op(C_MRS, 2'd0);
    op(C_ACT, 2'd0);
    settle_check("R12 first error held", 1'b1, 3'd1, 2'd1);
    nops(4);
    check("R12 still held", 1'b1, 3'd1, 2'd1);
    do_reset;
    @(negedge clk);
    check("R12 cleared by reset", 1'b0, 3'd0, 2'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule